// File: doc/BRIEF.md
# System Clock Source Selector with Four-Phase Machine-Cycle Sequencer

This block picks the time base for a small processor core. It takes three possible sources: the raw oscillator, a clock already multiplied up from the oscillator, and a low-power source. The low-power source comes from an internal 8-bit counter that fires once every 256 oscillator periods. The chosen source is the system clock. The timers and peripherals run from it. It also drives a sequencer that splits every four system clock periods into one machine cycle with four ordered phases. An instruction takes one to five of these machine cycles.

Everything runs in one fast clock domain. Each source appears as a single-cycle enable pulse on the fast clock, and the system clock leaves the block as an enable pulse too. A two-bit control register holds the requested source. The request is copied to the active source only when phase 4 of a machine cycle completes. A machine cycle is therefore never cut short or stretched across two sources.

Top module: `sysclk_mcycle`

## Requirements
- R1: While reset is high and right after it is released, `phase` is 4'b0001, `active_src` is 2'b00 (oscillator) and `mc_pulse` is 0.
- R2: `phase` is always one-hot, with bit 0 standing for phase 1 and bit 3 for phase 4. Each cycle with `sys_en` high moves it one step in the order 1, 2, 3, 4, 1.
- R3: When `active_src` is 2'b00, `sys_en` equals `osc_en` in the same cycle. A write of code 2'b11 is reserved and becomes `active_src` 2'b00.
- R4: When `active_src` is 2'b01, `sys_en` equals `mul_en` in the same cycle.
- R5: When `active_src` is 2'b10, `sys_en` is high only on every 256th `osc_en` pulse, counted by a free-running 8-bit counter that starts at zero on reset. The 256th `osc_en` pulse after reset is the first that passes.
- R6: `mc_pulse` is high for exactly the fast cycles in which `phase` is 4'b1000 and `sys_en` is high.
- R7: A write (`cfg_we` high, code on `cfg_src`) changes `active_src` only in the cycle after `mc_pulse`. That cycle takes the last code written before the `mc_pulse` cycle. A later request replaces an earlier one that has not yet taken effect.
- R8: In any cycle with `sys_en` low, `phase` keeps its value in the next cycle.
- R9: Every machine cycle, counted from one `mc_pulse` to the next, holds exactly four `sys_en` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from which every enable is derived |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator period |
| mul_en | input | 1 | One pulse per multiplied-clock period |
| cfg_we | input | 1 | Write strobe for the source request register |
| cfg_src | input | 2 | Requested source: 00 oscillator, 01 multiplied, 10 divide-by-256, 11 reserved |
| sys_en | output | 1 | System clock enable from the active source |
| phase | output | 4 | One-hot machine-cycle phase, bit 0 = phase 1 |
| mc_pulse | output | 1 | End-of-machine-cycle strobe, one fast cycle |
| active_src | output | 2 | Source currently in use |

## Verification
The hardest case to reach is a request that waits a long time in slow mode. There, one machine cycle lasts more than a thousand fast cycles. The stimulus writes an "oscillator" request early in a slow machine cycle and then overwrites it with "slow" again before the boundary. No switch may follow. It also writes a request in the exact cycle of `mc_pulse` and checks that the older code is the one applied. A reference model in the bench tracks the divider count, the phase and the pending request every cycle. It runs under sweeps of every source code against several enable patterns.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int SRC_W    = 2;
    localparam int NUM_PH   = 4;
    localparam int SLOW_DIV_W = 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_OSC  = 2'b00,
        SRC_MUL  = 2'b01,
        SRC_SLOW = 2'b10
    } src_e;

    typedef struct packed {
        logic osc;
        logic mul;
        logic slow;
    } en_bus_t;

    // Reserved code 2'b11 folds onto the oscillator source.
    function automatic src_e decode_src(input logic [SRC_W-1:0] code);
        case (code)
            2'b01:   return SRC_MUL;
            2'b10:   return SRC_SLOW;
            default: return SRC_OSC;
        endcase
    endfunction

endpackage

// File: rtl/sclk_slow_div.sv
module sclk_slow_div #(
    parameter int DIV_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    output logic slow_en
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (osc_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slow_en = osc_en && (cnt_q == {DIV_W{1'b1}});
endmodule

// File: rtl/sclk_src_mux.sv
module sclk_src_mux
    import sclk_pkg::*;
(
    input  src_e    sel,
    input  en_bus_t en,
    output logic    sys_en
);
    always_comb begin
        case (sel)
            SRC_MUL:  sys_en = en.mul;
            SRC_SLOW: sys_en = en.slow;
            default:  sys_en = en.osc;
        endcase
    end
endmodule

// File: rtl/sclk_phase_seq.sv
module sclk_phase_seq #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    output logic [NPH-1:0] phase,
    output logic           last
);
    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(NPH - 1);

    logic [PW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign phase[i] = (idx_q == PW'(i));
    end

    assign last = step && (idx_q == LAST_IDX);
endmodule

// File: rtl/sysclk_mcycle.sv
module sysclk_mcycle
    import sclk_pkg::*;
#(
    parameter int DIV_W = SLOW_DIV_W,
    parameter int NPH   = NUM_PH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             mul_en,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    output logic             sys_en,
    output logic [NPH-1:0]   phase,
    output logic             mc_pulse,
    output logic [SRC_W-1:0] active_src
);
    src_e    req_q;
    src_e    act_q;
    en_bus_t en_bus;
    logic    slow_en;

    sclk_slow_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .osc_en  (osc_en),
        .slow_en (slow_en)
    );

    assign en_bus = '{osc: osc_en, mul: mul_en, slow: slow_en};

    sclk_src_mux u_mux (
        .sel    (act_q),
        .en     (en_bus),
        .sys_en (sys_en)
    );

    sclk_phase_seq #(.NPH(NPH)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .step  (sys_en),
        .phase (phase),
        .last  (mc_pulse)
    );

    // Request register; the active source follows only at a cycle boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= SRC_OSC;
            act_q <= SRC_OSC;
        end else begin
            if (mc_pulse) act_q <= req_q;
            if (cfg_we)   req_q <= decode_src(cfg_src);
        end
    end

    assign active_src = act_q;
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk (
    input logic       clk,
    input logic       rst,
    input logic       mul_en,
    input logic       sys_en,
    input logic [3:0] phase,
    input logic       mc_pulse,
    input logic [1:0] active_src
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase == 4'b0001 && active_src == 2'b00));

    assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    assert_phase_rotate_R2: assert property (@(posedge clk) disable iff (rst)
        sys_en |=> phase == {$past(phase[2:0]), $past(phase[3])});

    assert_mul_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (active_src == 2'b01) |-> (sys_en == mul_en));

    assert_pulse_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        mc_pulse |=> phase == 4'b0001);

    assert_src_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !mc_pulse |=> $stable(active_src));

    assert_no_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        active_src != 2'b11);

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !sys_en |=> $stable(phase));
endmodule

bind sysclk_mcycle sclk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mul_en     (mul_en),
    .sys_en     (sys_en),
    .phase      (phase),
    .mc_pulse   (mc_pulse),
    .active_src (active_src)
);

// File: tb/sim_sysclk_mcycle.sv
module sim_sysclk_mcycle;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       mul_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       sys_en;
    logic [3:0] phase;
    logic       mc_pulse;
    logic [1:0] active_src;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_act = 0, m_req = 0, m_cnt = 0, m_ph = 0;
    int since_pulse = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    sysclk_mcycle u0 (
        .clk(clk), .rst(rst), .osc_en(osc_en), .mul_en(mul_en),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .sys_en(sys_en),
        .phase(phase), .mc_pulse(mc_pulse), .active_src(active_src)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int dec(input int code);
        return (code == 1 || code == 2) ? code : 0;
    endfunction

    // one fast cycle: drive at negedge, compare, advance model as of next posedge
    task automatic step(input int osc_mode, input bit we, input int code);
        bit o, m, slow, es, ep;
        @(negedge clk);
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (osc_mode)
            0: o = 1'b1;
            1: o = (cyc % 2) == 0;
            2: o = (cyc % 3) == 0;
            default: o = lfsr[3];
        endcase
        m = lfsr[7];
        osc_en = o; mul_en = m; cfg_we = we; cfg_src = code[1:0];
        #1;
        slow = o && (m_cnt == 255);
        es = (m_act == 1) ? m : (m_act == 2) ? slow : o;
        ep = es && (m_ph == 3);
        if (m_act == 1)      chk("R4 sys_en", int'(sys_en), int'(es));
        else if (m_act == 2) chk("R5 sys_en", int'(sys_en), int'(es));
        else                 chk("R3 sys_en", int'(sys_en), int'(es));
        chk(es ? "R2 phase" : "R8 phase", int'(phase), 1 << m_ph);
        chk("R6 mc_pulse", int'(mc_pulse), int'(ep));
        chk("R7 active_src", int'(active_src), m_act);
        if (sys_en) since_pulse++;
        if (mc_pulse) begin
            chk("R9 enables per machine cycle", since_pulse, 4);
            since_pulse = 0;
        end
        if (o) m_cnt = (m_cnt + 1) % 256;
        if (es) begin
            if (m_ph == 3) begin
                m_ph = 0;
                m_act = m_req;
            end else begin
                m_ph++;
            end
        end
        if (we) m_req = dec(code);
    endtask

    task automatic run(input int n, input int osc_mode);
        for (int i = 0; i < n; i++) step(osc_mode, 1'b0, 0);
    endtask

    // wait for a boundary, write in that very cycle
    task automatic write_on_pulse(input int code, input int osc_mode);
        for (int i = 0; i < 5000; i++) begin
            if (m_ph == 3 && m_act == 0 && osc_mode == 0) begin
                step(osc_mode, 1'b1, code);
                return;
            end
            step(osc_mode, 1'b0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            osc_en = 1'b1; mul_en = 1'b1;
            #1;
            chk("R1 reset phase", int'(phase), 1);
            chk("R1 reset source", int'(active_src), 0);
        end
        @(negedge clk);
        rst = 1'b0; osc_en = 1'b0; mul_en = 1'b0;
        #1;
        chk("R1 phase after reset", int'(phase), 1);
        chk("R1 source after reset", int'(active_src), 0);
        chk("R1 pulse after reset", int'(mc_pulse), 0);

        run(60, 2);                     // oscillator, sparse enables
        step(1, 1'b1, 1);               // request multiplied mid-cycle
        run(80, 1);
        step(3, 1'b1, 3);               // reserved code -> oscillator
        run(60, 3);
        write_on_pulse(1, 0);           // write in the boundary cycle: old request applies
        run(40, 0);
        step(0, 1'b1, 2);               // go slow
        run(300, 0);
        step(0, 1'b1, 0);               // pending oscillator request ...
        run(100, 0);
        step(0, 1'b1, 2);               // ... overwritten before boundary
        run(2200, 0);
        step(0, 1'b1, 0);
        run(1200, 0);
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                step(p, 1'b1, c);
                run((c == 2) ? 1100 : 40, (c == 2) ? 0 : p);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule